// File: doc/BRIEF.md
# Commit Result Checker with Register Rollback

This block checks redundant execution at instruction commit. Two copies of a thread run the same program: a leading copy and a trailing copy. Each time the leading copy commits an instruction, it pushes the instruction's PC, its destination register index, a destination-present flag and its 64-bit result into an in-order queue. Later the trailing copy commits the same instruction and presents its own version of those fields. The head entry of the queue is popped and compared with them. The trailing architectural register file sits inside the block. A result is written into that file only when it agrees with the head entry, so the file always holds a verified state.

On a disagreement the block starts recovery. It discards everything still queued and writes the 32 verified registers into the leading copy's register file, one register per cycle, over a write port. It then gives a one-cycle flush request for both pipelines, together with the PC of the instruction that failed the check, and execution restarts there. While recovery runs, both commit paths are stalled. Outside recovery, the leading copy stalls when the queue is full and the trailing copy stalls when it is empty. A read port on the verified register file lets the trailing copy read its operands.

Top module: `commit_check_rb`

## Requirements
- R1: After reset the queue is empty, `lead_ready_o`=1, `trail_ready_o`=0, `recover_busy_o`=0, `flush_o`=0, and every verified register reads 0.
- R2: The queue holds up to DEPTH=80 entries. `lead_ready_o` is 0 while 80 entries are held, and a push presented then is not accepted. Entries are compared in the order they were pushed.
- R3: `trail_ready_o` is 0 while the queue is empty, and a trailing commit presented then has no effect.
- R4: A trailing commit with `trail_rd_en_i`=1 matches when its PC, register index and value all equal the head entry's and the head has the flag set. On a match the value is written to that register, and `arf_rd_data_o` shows it from the following cycle.
- R5: An entry with the destination flag 0 matches a trailing commit with the flag 0 and the same PC, whatever the register index and value fields hold. Such a match writes no register.
- R6: A trailing commit that differs from the head in PC, in flag, or (with the flag set) in register index or value is a fault. A fault writes no register.
- R7: In the cycle after a fault `recover_busy_o` rises and stays high for exactly 32 cycles. During those cycles `lead_ready_o` and `trail_ready_o` are both 0.
- R8: During each recovery cycle `copy_we_o`=1. `copy_addr_o` steps through 0,1,…,31 in ascending order. `copy_data_o` equals the verified value of register `copy_addr_o`.
- R9: `flush_o` is high for exactly one cycle, the cycle right after `recover_busy_o` falls. `restart_pc_o` then holds the queued PC of the faulting entry, and it keeps that value until the next fault.
- R10: The fault clears the queue. A leading push accepted in the same cycle as the fault is discarded, so the queue is empty when recovery ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lead_valid_i | input | 1 | Leading copy presents a committed instruction |
| lead_ready_o | output | 1 | Queue can accept a push |
| lead_pc_i | input | 32 | PC of the leading commit |
| lead_rd_en_i | input | 1 | Leading instruction has a destination |
| lead_rd_i | input | 5 | Destination register index |
| lead_val_i | input | 64 | Leading result |
| trail_valid_i | input | 1 | Trailing copy presents a committed instruction |
| trail_ready_o | output | 1 | A queued entry is available to compare |
| trail_pc_i | input | 32 | PC of the trailing commit |
| trail_rd_en_i | input | 1 | Trailing instruction has a destination |
| trail_rd_i | input | 5 | Destination register index |
| trail_val_i | input | 64 | Trailing result |
| arf_rd_addr_i | input | 5 | Verified register file read index |
| arf_rd_data_o | output | 64 | Verified register file read data |
| recover_busy_o | output | 1 | Register copy in progress |
| copy_we_o | output | 1 | Write enable into the leading register file |
| copy_addr_o | output | 5 | Register index being copied |
| copy_data_o | output | 64 | Verified value being copied |
| flush_o | output | 1 | One-cycle request to flush both pipelines |
| restart_pc_o | output | 32 | PC to restart from after the flush |

## Verification
The assertions assume that neither copy treats a commit as accepted unless its ready output was high. They also assume that the start request never reaches the recovery unit while a copy is in progress, because the block itself masks both ready outputs during recovery. The stimulus changes every input on the falling clock edge. It raises a valid only for single-cycle handshakes. It keeps the valids low through recovery, except in the scenarios that check on purpose that a push into a full queue or a commit against an empty queue is ignored.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned DEF_DEPTH = 80;
  localparam int unsigned DEF_XLEN  = 64;
  localparam int unsigned DEF_PC_W  = 32;
  localparam int unsigned DEF_NREG  = 32;

  typedef enum logic [0:0] {
    RS_RUN  = 1'b0,
    RS_COPY = 1'b1
  } rec_state_e;
endpackage

// File: rtl/ccr_fifo.sv
module ccr_fifo #(
  parameter int unsigned DEPTH = 80,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clear_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout_o  = mem[rd_ptr];
  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign empty_o = (cnt == '0);

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt < CNT_W'(DEPTH));
  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt != '0);
  a_r10_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt == '0);
endmodule

// File: rtl/ccr_arf.sv
module ccr_arf #(
  parameter int unsigned NREG = 32,
  parameter int unsigned XLEN = 64,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_a_i,
  output logic [XLEN-1:0] rdata_a_o,
  input  logic [AW-1:0]   raddr_b_i,
  output logic [XLEN-1:0] rdata_b_o
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs[g] <= '0;
      else if (we_i && waddr_i == AW'(g))      regs[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
endmodule

// File: rtl/ccr_recover.sv
module ccr_recover
  import ccr_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned PC_W = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [PC_W-1:0] start_pc_i,
  output logic            busy_o,
  output logic [AW-1:0]   idx_o,
  output logic            flush_o,
  output logic [PC_W-1:0] restart_pc_o
);
  rec_state_e      state;
  logic [AW-1:0]   idx;
  logic            flush_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= RS_RUN;
      idx     <= '0;
      flush_q <= 1'b0;
      pc_q    <= '0;
    end else begin
      flush_q <= 1'b0;
      unique case (state)
        RS_RUN: if (start_i) begin
          state <= RS_COPY;
          idx   <= '0;
          pc_q  <= start_pc_i;
        end
        RS_COPY: begin
          idx <= idx + 1'b1;
          if (idx == AW'(NREG - 1)) begin
            state   <= RS_RUN;
            flush_q <= 1'b1;
          end
        end
        default: state <= RS_RUN;
      endcase
    end
  end

  assign busy_o       = (state == RS_COPY);
  assign idx_o        = idx;
  assign flush_o      = flush_q;
  assign restart_pc_o = pc_q;

  a_r7_no_start_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
  a_r8_idx_ascends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> idx_o == $past(idx_o) + 1'b1);
  a_r8_copy_starts_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> idx_o == '0);
  a_r9_flush_after_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> flush_o);
  a_r9_flush_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
endmodule

// File: rtl/commit_check_rb.sv
module commit_check_rb
  import ccr_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned XLEN  = DEF_XLEN,
  parameter int unsigned PC_W  = DEF_PC_W,
  parameter int unsigned NREG  = DEF_NREG,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lead_valid_i,
  output logic            lead_ready_o,
  input  logic [PC_W-1:0] lead_pc_i,
  input  logic            lead_rd_en_i,
  input  logic [AW-1:0]   lead_rd_i,
  input  logic [XLEN-1:0] lead_val_i,
  input  logic            trail_valid_i,
  output logic            trail_ready_o,
  input  logic [PC_W-1:0] trail_pc_i,
  input  logic            trail_rd_en_i,
  input  logic [AW-1:0]   trail_rd_i,
  input  logic [XLEN-1:0] trail_val_i,
  input  logic [AW-1:0]   arf_rd_addr_i,
  output logic [XLEN-1:0] arf_rd_data_o,
  output logic            recover_busy_o,
  output logic            copy_we_o,
  output logic [AW-1:0]   copy_addr_o,
  output logic [XLEN-1:0] copy_data_o,
  output logic            flush_o,
  output logic [PC_W-1:0] restart_pc_o
);
  localparam int unsigned ENT_W = PC_W + 1 + AW + XLEN;

  logic             q_full, q_empty, push, pop, match, fault, rf_we, busy;
  logic [ENT_W-1:0] q_din, q_dout;
  logic [PC_W-1:0]  h_pc;
  logic             h_en;
  logic [AW-1:0]    h_rd, idx;
  logic [XLEN-1:0]  h_val;

  assign q_din = {lead_pc_i, lead_rd_en_i, lead_rd_i, lead_val_i};
  assign {h_pc, h_en, h_rd, h_val} = q_dout;

  assign lead_ready_o  = !q_full && !busy;
  assign trail_ready_o = !q_empty && !busy;
  assign push = lead_valid_i && lead_ready_o;
  assign pop  = trail_valid_i && trail_ready_o;

  // no-destination entries are checked on PC alone
  always_comb begin
    match = (h_pc == trail_pc_i) && (h_en == trail_rd_en_i);
    if (h_en) match = match && (h_rd == trail_rd_i) && (h_val == trail_val_i);
  end

  assign fault = pop && !match;
  assign rf_we = pop && match && trail_rd_en_i;

  ccr_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_queue (
    .clk_i, .rst_ni,
    .clear_i (fault),
    .push_i  (push),
    .din_i   (q_din),
    .pop_i   (pop),
    .dout_o  (q_dout),
    .full_o  (q_full),
    .empty_o (q_empty)
  );

  ccr_arf #(.NREG(NREG), .XLEN(XLEN)) u_arf (
    .clk_i, .rst_ni,
    .we_i      (rf_we),
    .waddr_i   (trail_rd_i),
    .wdata_i   (trail_val_i),
    .raddr_a_i (arf_rd_addr_i),
    .rdata_a_o (arf_rd_data_o),
    .raddr_b_i (idx),
    .rdata_b_o (copy_data_o)
  );

  ccr_recover #(.NREG(NREG), .PC_W(PC_W)) u_rec (
    .clk_i, .rst_ni,
    .start_i      (fault),
    .start_pc_i   (h_pc),
    .busy_o       (busy),
    .idx_o        (idx),
    .flush_o      (flush_o),
    .restart_pc_o (restart_pc_o)
  );

  assign recover_busy_o = busy;
  assign copy_we_o      = busy;
  assign copy_addr_o    = idx;

  a_r7_stall_in_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_busy_o |-> !lead_ready_o && !trail_ready_o);
  a_r7_busy_after_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trail_valid_i && trail_ready_o && !match) |=> recover_busy_o);
  a_r10_empty_at_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !trail_ready_o);
  a_r9_restart_pc_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $stable(restart_pc_o));
endmodule

// File: tb/tb_commit_check_rb.sv
module tb_commit_check_rb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lv = 1'b0, len = 1'b0, tv = 1'b0, ten = 1'b0;
  logic [31:0] lpc = '0, tpc = '0;
  logic [4:0]  lrd = '0, trd = '0, raddr = '0;
  logic [63:0] lval = '0, tval = '0;
  logic        lrdy, trdy, busy, cwe, flush;
  logic [4:0]  caddr;
  logic [63:0] rdata, cdata;
  logic [31:0] rpc;

  logic [63:0] m_rf [32];
  int n_vec = 0, n_fail = 0;

  always #10 clk = ~clk;

  commit_check_rb dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lead_valid_i(lv), .lead_ready_o(lrdy), .lead_pc_i(lpc), .lead_rd_en_i(len),
    .lead_rd_i(lrd), .lead_val_i(lval),
    .trail_valid_i(tv), .trail_ready_o(trdy), .trail_pc_i(tpc), .trail_rd_en_i(ten),
    .trail_rd_i(trd), .trail_val_i(tval),
    .arf_rd_addr_i(raddr), .arf_rd_data_o(rdata),
    .recover_busy_o(busy), .copy_we_o(cwe), .copy_addr_o(caddr), .copy_data_o(cdata),
    .flush_o(flush), .restart_pc_o(rpc)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  // one cycle: drive at negedge, release at next negedge
  task automatic step(input logic l_v, input logic [31:0] l_pc, input logic l_en,
                      input logic [4:0] l_rd, input logic [63:0] l_val,
                      input logic t_v, input logic [31:0] t_pc, input logic t_en,
                      input logic [4:0] t_rd, input logic [63:0] t_val);
    @(negedge clk);
    lv = l_v; lpc = l_pc; len = l_en; lrd = l_rd; lval = l_val;
    tv = t_v; tpc = t_pc; ten = t_en; trd = t_rd; tval = t_val;
    @(negedge clk);
    lv = 1'b0; tv = 1'b0;
  endtask

  task automatic lead(input logic [31:0] pc, input logic en, input logic [4:0] rd,
                      input logic [63:0] v);
    step(1'b1, pc, en, rd, v, 1'b0, '0, 1'b0, '0, '0);
  endtask

  task automatic trail(input logic [31:0] pc, input logic en, input logic [4:0] rd,
                       input logic [63:0] v);
    step(1'b0, '0, 1'b0, '0, '0, 1'b1, pc, en, rd, v);
  endtask

  task automatic read_chk(input string req, input logic [4:0] a);
    raddr = a; #1;
    check(req, rdata, m_rf[a]);
  endtask

  task automatic t_reset;
    check("R1 lead_ready", lrdy, 1);
    check("R1 trail_ready", trdy, 0);
    check("R1 busy", busy, 0);
    check("R1 flush", flush, 0);
    for (int i = 0; i < 32; i += 7) read_chk("R1 reg zero", 5'(i));
  endtask

  task automatic t_match;
    lead(32'h100, 1, 5'd3, 64'hDEAD_BEEF_0000_0003);
    lead(32'h104, 1, 5'd9, 64'h1234_5678_9ABC_DEF0);
    lead(32'h108, 1, 5'd3, 64'h0000_0000_0000_0033);
    trail(32'h100, 1, 5'd3, 64'hDEAD_BEEF_0000_0003); m_rf[3] = 64'hDEAD_BEEF_0000_0003;
    read_chk("R4 first match", 5'd3);
    trail(32'h104, 1, 5'd9, 64'h1234_5678_9ABC_DEF0); m_rf[9] = 64'h1234_5678_9ABC_DEF0;
    read_chk("R4 second match", 5'd9);
    trail(32'h108, 1, 5'd3, 64'h33); m_rf[3] = 64'h33;
    read_chk("R2 order, R4 overwrite", 5'd3);
    check("R3 empty stalls trail", trdy, 0);
    check("R4 no fault", busy, 0);
  endtask

  task automatic t_nodest;
    lead(32'h200, 0, 5'd9, 64'h5555);
    trail(32'h200, 0, 5'd4, 64'hAAAA);
    check("R5 pc-only match no recovery", busy, 0);
    check("R5 entry consumed", trdy, 0);
    read_chk("R5 reg9 untouched", 5'd9);
    read_chk("R5 reg4 untouched", 5'd4);
  endtask

  task automatic t_empty_ignored;
    trail(32'h999, 1, 5'd9, 64'hFFFF);
    check("R3 empty commit no recovery", busy, 0);
    read_chk("R3 empty commit no write", 5'd9);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 80; i++) lead(32'h1000 + 32'(4 * i), 1, 5'(i % 32), 64'(i * 3 + 7));
    check("R2 full stalls lead", lrdy, 0);
    lead(32'hBAD0, 1, 5'd0, 64'hBAD);
    for (int i = 0; i < 80; i++) begin
      trail(32'h1000 + 32'(4 * i), 1, 5'(i % 32), 64'(i * 3 + 7));
      m_rf[i % 32] = 64'(i * 3 + 7);
    end
    check("R2 80 matches no fault", busy, 0);
    check("R2 extra push dropped", trdy, 0);
    read_chk("R2 last wrap value", 5'd15);
    read_chk("R2 last wrap value", 5'd16);
  endtask

  task automatic t_fault;
    int nbusy;
    lead(32'h300, 1, 5'd7, 64'h77);
    lead(32'h304, 1, 5'd8, 64'h88);
    trail(32'h300, 1, 5'd7, 64'h77); m_rf[7] = 64'h77;
    // bad value on second entry, with a push in the same cycle
    step(1'b1, 32'h308, 1, 5'd1, 64'h11, 1'b1, 32'h304, 1, 5'd8, 64'h89);
    check("R7 busy after fault", busy, 1);
    check("R7 lead stalled", lrdy, 0);
    check("R7 trail stalled", trdy, 0);
    nbusy = 0;
    for (int k = 0; k < 32; k++) begin
      if (busy) nbusy++;
      check("R8 copy we", cwe, 1);
      check("R8 copy addr", caddr, 64'(k));
      check("R8 copy data", cdata, m_rf[k]);
      @(negedge clk);
    end
    check("R7 busy 32 cycles", nbusy, 32);
    check("R7 busy fallen", busy, 0);
    check("R9 flush pulse", flush, 1);
    check("R9 restart pc", rpc, 32'h304);
    @(negedge clk);
    check("R9 flush single", flush, 0);
    check("R9 restart pc held", rpc, 32'h304);
    check("R10 queue cleared", trdy, 0);
    check("R10 lead resumes", lrdy, 1);
    read_chk("R6 faulty value not written", 5'd8);
  endtask

  task automatic t_fault_flag;
    int nbusy;
    lead(32'h400, 1, 5'd2, 64'h22);
    trail(32'h400, 0, 5'd2, 64'h22);
    check("R6 flag mismatch faults", busy, 1);
    nbusy = 0;
    while (busy && nbusy < 40) begin nbusy++; @(negedge clk); end
    check("R7 busy 32 cycles", nbusy, 32);
    check("R9 flush after flag fault", flush, 1);
    check("R9 restart pc", rpc, 32'h400);
    read_chk("R6 reg2 untouched", 5'd2);
    lead(32'h500, 1, 5'd2, 64'h22);
    trail(32'h504, 1, 5'd2, 64'h22);
    check("R6 pc mismatch faults", busy, 1);
    repeat (34) @(negedge clk);
    check("R9 restart pc updated", rpc, 32'h500);
    read_chk("R6 reg2 still untouched", 5'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_match();
    t_nodest();
    t_empty_ignored();
    t_fill();
    t_fault();
    t_fault_flag();
    report();
  end
endmodule